// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block sits on the receive path of a CAN physical-layer interface. It takes a clocked digital indication that the differential bus is dominant and produces the receive-data line for the protocol controller. In normal mode the receive line follows the bus with one register of delay: low for dominant, high for recessive.

In standby the block acts as a low-power bus monitor. A dominant period counts as a wake-up request only if it lasts `FILT_CYCLES` consecutive clock samples. The receive line then goes low and stays low until the bus returns to recessive. Shorter dominant periods are dropped entirely. Each recessive sample clears the count, so bursts of short glitches never add up to a wake request.

The mode select has a separate "driven" qualifier. When the select is not driven, the block treats it as standby. Any change of mode clears the pulse counter, so a partial count never carries from one mode into the other. The default filter length is 30 cycles, which is 3 µs at a 10 MHz clock.

Top module: `can_stby_wake`

## Requirements
- R1: While reset is asserted and right after it is released, rx_data is high (1 = recessive / no wake request) and the dominant-pulse count is zero.
- R2: In normal mode (standby resolved low), rx_data after each clock edge equals the inverse of bus_dom sampled at that edge (bus_dom 1 = dominant gives rx_data 0).
- R3: In standby, rx_data goes low at the clock edge that samples the FILT_CYCLES-th consecutive dominant bus_dom.
- R4: In standby, a dominant run of fewer than FILT_CYCLES samples leaves rx_data high throughout.
- R5: In standby, dominant runs each shorter than FILT_CYCLES but separated by recessive samples do not accumulate: rx_data stays high.
- R6: A recessive sample clears the dominant count, and rx_data is high after that edge in either mode.
- R7: When sel_driven is 0, the block is in standby regardless of stby_sel (stby_sel 1 = standby).
- R8: The edge at which the resolved mode changes clears the count. After a switch into standby with the bus already dominant, FILT_CYCLES further dominant samples are needed before rx_data goes low.
- R9: The count saturates at FILT_CYCLES, so a dominant run of any length beyond that keeps rx_data low with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_dom | input | 1 | 1 when the thresholded bus is dominant |
| stby_sel | input | 1 | Mode select, 1 = standby, 0 = normal |
| sel_driven | input | 1 | 1 when stby_sel is actively driven; 0 forces standby |
| rx_data | output | 1 | Receive data / active-low wake request |

## Verification
The assertions check the following on every cycle:
- the one-cycle mirror in normal mode;
- clearing of the count on a recessive sample and on a mode change;
- the bound on the count;
- that a standby fall of rx_data only happens with a full count;
- that an undriven select resolves to standby.

Several behaviours show only across whole scenarios, so the bench covers them:
- the exact cycle at which a wake request appears for runs just below, at and just above the filter length;
- that glitch bursts do not accumulate;
- that a long dominant run does not wrap;
- the extra cycle of count needed after a mode switch into standby.

// File: rtl/can_stby_wake_pkg.sv
package can_stby_wake_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } wake_mode_e;

  // Resolve the select: an undriven select defaults to standby.
  function automatic wake_mode_e resolve_mode(input logic sel, input logic driven);
    return (!driven || sel) ? MODE_STANDBY : MODE_NORMAL;
  endfunction

  // Receive output value for a given mode, bus level and qualification.
  function automatic logic rx_level(input wake_mode_e mode, input logic dom,
                                    input logic qual);
    return (mode == MODE_STANDBY) ? !qual : !dom;
  endfunction

endpackage

// File: rtl/stby_mode_ctl.sv
module stby_mode_ctl
  import can_stby_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_sel,
  input  logic       sel_driven,
  output wake_mode_e mode_now,
  output wake_mode_e mode_q,
  output logic       mode_change
);

  assign mode_now    = resolve_mode(stby_sel, sel_driven);
  assign mode_change = (mode_now != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_STANDBY;
    else        mode_q <= mode_now;
  end

  assert_undriven_stby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_driven |=> (mode_q == MODE_STANDBY));

endmodule

// File: rtl/dom_width_filter.sv
module dom_width_filter #(
  parameter int FILT_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_dom,
  input  logic clear,
  output logic [$clog2(FILT_CYCLES+1)-1:0] cnt_q,
  output logic qualified
);

  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_next;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                               input logic dom, input logic clr);
    if (clr || !dom)      return '0;
    else if (cur < LIMIT) return cur + 1'b1;
    else                  return cur;
  endfunction

  assign cnt_next  = next_count(cnt_q, bus_dom, clear);
  assign qualified = (cnt_next == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  assert_recessive_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dom |=> (cnt_q == '0));

  assert_mode_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/rxd_out_sel.sv
module rxd_out_sel
  import can_stby_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wake_mode_e mode_now,
  input  logic       bus_dom,
  input  logic       qualified,
  output logic       rx_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_level(mode_now, bus_dom, qualified);
  end

  assert_normal_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_NORMAL) |=> (rx_q == !$past(bus_dom)));

  assert_recessive_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dom |=> rx_q);

endmodule

// File: rtl/can_stby_wake.sv
module can_stby_wake
  import can_stby_wake_pkg::*;
#(
  parameter int FILT_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_dom,
  input  logic stby_sel,
  input  logic sel_driven,
  output logic rx_data
);

  localparam int CW = $clog2(FILT_CYCLES + 1);

  wake_mode_e    mode_now;
  wake_mode_e    mode_q;
  logic          mode_change;
  logic [CW-1:0] dom_cnt;
  logic          qualified;

  stby_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .stby_sel    (stby_sel),
    .sel_driven  (sel_driven),
    .mode_now    (mode_now),
    .mode_q      (mode_q),
    .mode_change (mode_change)
  );

  dom_width_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_dom   (bus_dom),
    .clear     (mode_change),
    .cnt_q     (dom_cnt),
    .qualified (qualified)
  );

  rxd_out_sel u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_now  (mode_now),
    .bus_dom   (bus_dom),
    .qualified (qualified),
    .rx_q      (rx_data)
  );

  assert_wake_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (qualified && mode_now == MODE_STANDBY) |=> !rx_data);

  assert_no_short_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_STANDBY) && $fell(rx_data)) |-> (dom_cnt == CW'(FILT_CYCLES)));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (rx_data && dom_cnt == '0));

endmodule

// File: tb/test_can_stby_wake.sv
module test_can_stby_wake;

  localparam int CLK_PERIOD = 10;
  localparam int FILT = 30;
  localparam int NROWS = 8;
  // Row: mode (1 standby), dominant length
  localparam int ROW_MODE[NROWS] = '{1, 1, 1, 1, 1, 1, 0, 0};
  localparam int ROW_LEN [NROWS] = '{1, 7, FILT-1, FILT, FILT+1, 3*FILT, 1, 5};

  logic clk = 1'b0;
  logic rst_n, bus_dom, stby_sel, sel_driven;
  wire  rx_data;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stby_wake #(.FILT_CYCLES(FILT)) i_can_stby_wake (
    .clk(clk), .rst_n(rst_n), .bus_dom(bus_dom), .stby_sel(stby_sel),
    .sel_driven(sel_driven), .rx_data(rx_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input bit stby);
    bus_dom = 1'b0; sel_driven = 1'b1; stby_sel = stby;
    step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_dom = 1'b1; stby_sel = 1'b0; sel_driven = 1'b1;
    step(3);
    check(rx_data == 1'b1, "R1 in reset", rx_data, 1);
    rst_n = 1'b1;
    bus_dom = 1'b0;
    step(1);
    check(rx_data == 1'b1, "R1 after release", rx_data, 1);

    // Table walk: R2 normal rows, R3/R4/R9 standby rows, R6 recovery
    for (int r = 0; r < NROWS; r++) begin
      int bad = 0;
      int last = 1;
      set_mode(ROW_MODE[r] != 0);
      bus_dom = 1'b1;
      for (int i = 1; i <= ROW_LEN[r]; i++) begin
        int exp;
        step(1);
        exp = (ROW_MODE[r] == 0) ? 0 : ((i >= FILT) ? 0 : 1);
        if (rx_data !== exp[0]) begin bad++; last = rx_data; end
      end
      if (ROW_MODE[r] == 0)
        check(bad == 0, "R2 normal mirror", bad, 0);
      else if (ROW_LEN[r] < FILT)
        check(bad == 0, "R4 short pulse ignored", bad, 0);
      else if (ROW_LEN[r] > 2*FILT)
        check(bad == 0, "R9 long run stays low", bad, 0);
      else
        check(bad == 0, "R3 wake at filter length", bad, 0);
      bus_dom = 1'b0;
      step(1);
      check(rx_data == 1'b1, "R6 high after recessive", rx_data, 1);
    end

    // R2: alternating pattern in normal mode, one-cycle lag
    set_mode(1'b0);
    for (int i = 0; i < 8; i++) begin
      bus_dom = i[0];
      step(1);
      check(rx_data == !i[0], "R2 alternating", rx_data, !i[0]);
    end

    // R5: bursts of FILT-1 separated by single recessive samples
    set_mode(1'b1);
    begin
      int lows = 0;
      for (int p = 0; p < 6; p++) begin
        bus_dom = 1'b1;
        for (int i = 0; i < FILT-1; i++) begin step(1); if (!rx_data) lows++; end
        bus_dom = 1'b0;
        step(1);
        if (!rx_data) lows++;
      end
      check(lows == 0, "R5 no accumulation", lows, 0);
    end

    // R7: undriven select behaves as standby even with stby_sel=0
    bus_dom = 1'b0; stby_sel = 1'b0; sel_driven = 1'b0;
    step(3);
    bus_dom = 1'b1;
    step(FILT-1);
    check(rx_data == 1'b1, "R7 undriven is standby (short)", rx_data, 1);
    step(1);
    check(rx_data == 1'b0, "R7 undriven is standby (wake)", rx_data, 0);
    bus_dom = 1'b0;
    step(1);

    // R8: dominant across a normal->standby switch restarts the count
    set_mode(1'b0);
    bus_dom = 1'b1;
    step(FILT + 5);
    check(rx_data == 1'b0, "R8 normal dominant", rx_data, 0);
    stby_sel = 1'b1;
    step(1);
    check(rx_data == 1'b1, "R8 switch edge clears", rx_data, 1);
    step(FILT - 1);
    check(rx_data == 1'b1, "R8 still counting", rx_data, 1);
    step(1);
    check(rx_data == 1'b0, "R8 wake after fresh count", rx_data, 0);
    bus_dom = 1'b0;
    step(1);

    // R1: reset mid-wake returns output high
    bus_dom = 1'b1;
    step(FILT + 2);
    rst_n = 1'b0;
    step(1);
    check(rx_data == 1'b1, "R1 reset clears wake", rx_data, 1);
    rst_n = 1'b1;
    step(FILT - 1);
    check(rx_data == 1'b1, "R1 count zero after reset", rx_data, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule